// File: doc/BRIEF.md
# Memory Strobe Latency Sampler

This block sits in the physical layer of a HyperBus-style memory controller. During the command/address phase of a transaction, the memory device drives its read-write data strobe to say how much initial latency the access needs. A low strobe means the configured latency applies once. A high strobe means it applies twice. Under worst-case timing the strobe is stable for only about one clock period, roughly two to three cycles after chip select falls. The capture point therefore has to be placed precisely.

The block watches chip select on the free-running clock. The rising clock edge on which chip select is first seen low is edge 0. From there the block counts half-cycle edges up to a programmed target. Exactly one capture edge is let through to the strobe flop, on the rising or the falling clock edge as the target requires. A sticky start bit on the ungated clock arms the counter and drops when the target is reached. The captured bit is the only value that crosses into the PHY clock domain. There it produces a one-cycle valid pulse and a latency-doubling flag. The block also delays the start of the memory clock after chip select falls by a programmable number of cycles.

Top module: `rwds_lat_sampler`

## Requirements
- R1: The strobe is captured at half-edge T after edge 0, where edge 0 is the first rising clock edge that sees chip select low. An even T captures on the rising edge T/2 cycles after edge 0. An odd T captures on the falling edge (T-1)/2 cycles plus one half cycle after edge 0.
- R2: A sample-point value of 0 behaves exactly like 1, so the capture happens on the first falling edge after edge 0.
- R3: `lat_double_o` equals the captured strobe level: 1 if the strobe was high (latency doubled), 0 if it was low (single latency).
- R4: With the default of two synchroniser stages and equal clocks, `lat_valid_o` is high for exactly one PHY cycle per sampled transaction. It goes high after the rising edge (T-1)/2 + 3 cycles after edge 0.
- R5: When `no_lat_i` is high at edge 0 (zero-latency write), nothing is captured, no valid pulse occurs, and `lat_double_o` is 0.
- R6: `sample_pt_i`, `ck_delay_i` and `no_lat_i` are taken only at edge 0. Changes during the transaction have no effect.
- R7: `ck_en_o` rises after the rising edge D cycles after edge 0, where D = `ck_delay_i`, or 1 if `ck_delay_i` is 0. It is low at edge 0, and it is low after any rising edge that sees chip select high.
- R8: A new chip-select fall clears the previous `lat_double_o` before the next result arrives.
- R9: While `rst_ni` is low, `ck_en_o`, `lat_valid_o` and `lat_double_o` are 0. This includes a reset applied in the middle of a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running memory-side clock; both edges are used for capture |
| clk_phy_i | input | 1 | PHY/FSM domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| cs_n_i | input | 1 | Chip select, active low |
| rwds_i | input | 1 | Read-write data strobe from the device |
| no_lat_i | input | 1 | High for zero-latency writes; sampling is skipped |
| sample_pt_i | input | TGT_W (4) | Capture point in half cycles after edge 0; 0 means 1 |
| ck_delay_i | input | CKD_W (3) | Cycles from edge 0 to memory clock enable; 0 means 1 |
| ck_en_o | output | 1 | Enable for the memory clock gate |
| lat_valid_o | output | 1 | One-cycle pulse in the PHY domain when a result is ready |
| lat_double_o | output | 1 | Captured strobe level; 1 requests doubled latency |

## Verification
On every cycle, the assertions check the following: the arming counter never passes its hit index, a zero-latency start never arms, the memory clock enable drops whenever chip select is high or a transaction starts, and the valid pulse lasts a single cycle and carries the captured bit. Some behaviours only the bench scenarios can show. These are the exact half-edge the strobe is taken on, the mapping of setting 0 to the first falling edge, the arrival cycle of the valid pulse, the clock-start delay, and the clearing of a stale result. To show them, the bench drives the strobe with windows that open and close at different half-edges and compares the flag with the level inside or outside each window.

// File: rtl/rwds_lat_pkg.sv
package rwds_lat_pkg;

   // Which clock edge holds the captured strobe for the current transaction
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } cap_edge_e;

   localparam int unsigned DEF_TGT_W   = 4;
   localparam int unsigned DEF_CKD_W   = 3;
   localparam int unsigned DEF_SYNC_ST = 2;

endpackage

// File: rtl/rwds_lat_ckstart.sv
module rwds_lat_ckstart #(
   parameter int unsigned CKD_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cs_n_i,
   input  logic [CKD_W-1:0] ck_delay_i,
   output logic             start_o,
   output logic             ck_en_o
);

   localparam logic [CKD_W-1:0] ONE = CKD_W'(1);

   logic             cs_n_q;
   logic [CKD_W-1:0] cyc_q;
   logic [CKD_W-1:0] dly_q;
   logic             ck_en_q;

   assign start_o = cs_n_q & ~cs_n_i;
   assign ck_en_o = ck_en_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cs_n_q  <= 1'b1;
         cyc_q   <= '0;
         dly_q   <= ONE;
         ck_en_q <= 1'b0;
      end else begin
         cs_n_q <= cs_n_i;
         if (cs_n_i) begin
            ck_en_q <= 1'b0;
            cyc_q   <= '0;
         end else if (start_o) begin
            ck_en_q <= 1'b0;
            cyc_q   <= '0;
            dly_q   <= (ck_delay_i == '0) ? ONE : ck_delay_i;
         end else begin
            ck_en_q <= (cyc_q >= (dly_q - ONE));
            if (cyc_q != '1) cyc_q <= cyc_q + ONE;
         end
      end
   end

endmodule

// File: rtl/rwds_lat_capture.sv
module rwds_lat_capture
   import rwds_lat_pkg::*;
#(
   parameter int unsigned TGT_W = 4,
   localparam int unsigned CNT_W = TGT_W - 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             no_lat_i,
   input  logic [TGT_W-1:0] sample_pt_i,
   input  logic             rwds_i,
   output logic             armed_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] hit_idx_o,
   output logic             done_o,
   output logic             sample_o
);

   logic [TGT_W-1:0] tgt_eff;
   logic [TGT_W-1:0] tgt_m1;
   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] hit_q;
   cap_edge_e        edge_q;
   logic             done_q;
   logic             hit;
   logic             gate_rise;
   logic             gate_fall;
   logic             smp_rise_q;
   logic             smp_fall_q;

   assign tgt_eff = (sample_pt_i == '0) ? TGT_W'(1) : sample_pt_i;
   assign tgt_m1  = tgt_eff - TGT_W'(1);

   // One capture edge passes per transaction: the counter hits once, then armed drops
   assign hit       = armed_q && (cnt_q == hit_q);
   assign gate_rise = hit && (edge_q == EDGE_RISE);
   assign gate_fall = hit && (edge_q == EDGE_FALL);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
         hit_q   <= '0;
         edge_q  <= EDGE_RISE;
         done_q  <= 1'b0;
      end else if (start_i) begin
         armed_q <= ~no_lat_i;
         cnt_q   <= '0;
         hit_q   <= tgt_m1[TGT_W-1:1];
         edge_q  <= cap_edge_e'(tgt_eff[0]);
         done_q  <= 1'b0;
      end else if (armed_q) begin
         if (hit) begin
            armed_q <= 1'b0;
            done_q  <= 1'b1;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        smp_rise_q <= 1'b0;
      else if (gate_rise) smp_rise_q <= rwds_i;
   end

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        smp_fall_q <= 1'b0;
      else if (gate_fall) smp_fall_q <= rwds_i;
   end

   assign sample_o  = (edge_q == EDGE_FALL) ? smp_fall_q : smp_rise_q;
   assign armed_o   = armed_q;
   assign cnt_o     = cnt_q;
   assign hit_idx_o = hit_q;
   assign done_o    = done_q;

endmodule

// File: rtl/rwds_lat_phy_sync.sv
module rwds_lat_phy_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_phy_i,
   input  logic rst_ni,
   input  logic done_i,
   input  logic sample_i,
   output logic valid_o,
   output logic flag_o
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   valid_q;
   logic                   flag_q;
   logic                   rise;
   logic                   fall;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk_phy_i or negedge rst_ni) begin
            if (!rst_ni) sync_q[0] <= 1'b0;
            else         sync_q[0] <= done_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_phy_i or negedge rst_ni) begin
            if (!rst_ni) sync_q[i] <= 1'b0;
            else         sync_q[i] <= sync_q[i-1];
         end
      end
   end

   assign rise = sync_q[SYNC_STAGES-2] & ~sync_q[SYNC_STAGES-1];
   assign fall = ~sync_q[SYNC_STAGES-2] & sync_q[SYNC_STAGES-1];

   // sample_i has been stable since done rose, so it is safe to take here
   always_ff @(posedge clk_phy_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q <= 1'b0;
         flag_q  <= 1'b0;
      end else begin
         valid_q <= rise;
         if (rise)      flag_q <= sample_i;
         else if (fall) flag_q <= 1'b0;
      end
   end

   assign valid_o = valid_q;
   assign flag_o  = flag_q;

endmodule

// File: rtl/rwds_lat_sampler.sv
module rwds_lat_sampler
   import rwds_lat_pkg::*;
#(
   parameter int unsigned TGT_W       = DEF_TGT_W,
   parameter int unsigned CKD_W       = DEF_CKD_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_ST,
   localparam int unsigned CNT_W      = TGT_W - 1
) (
   input  logic             clk_i,
   input  logic             clk_phy_i,
   input  logic             rst_ni,
   input  logic             cs_n_i,
   input  logic             rwds_i,
   input  logic             no_lat_i,
   input  logic [TGT_W-1:0] sample_pt_i,
   input  logic [CKD_W-1:0] ck_delay_i,
   output logic             ck_en_o,
   output logic             lat_valid_o,
   output logic             lat_double_o
);

   if (TGT_W < 2) begin : g_bad_tgt
      $error("TGT_W must be at least 2");
   end
   if (CKD_W < 1) begin : g_bad_ckd
      $error("CKD_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic             start_w;
   logic             armed_w;
   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] hit_idx_w;
   logic             done_w;
   logic             sample_w;

   rwds_lat_ckstart #(.CKD_W(CKD_W)) u_ckstart (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cs_n_i     (cs_n_i),
      .ck_delay_i (ck_delay_i),
      .start_o    (start_w),
      .ck_en_o    (ck_en_o)
   );

   rwds_lat_capture #(.TGT_W(TGT_W)) u_capture (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_w),
      .no_lat_i    (no_lat_i),
      .sample_pt_i (sample_pt_i),
      .rwds_i      (rwds_i),
      .armed_o     (armed_w),
      .cnt_o       (cnt_w),
      .hit_idx_o   (hit_idx_w),
      .done_o      (done_w),
      .sample_o    (sample_w)
   );

   rwds_lat_phy_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk_phy_i (clk_phy_i),
      .rst_ni    (rst_ni),
      .done_i    (done_w),
      .sample_i  (sample_w),
      .valid_o   (lat_valid_o),
      .flag_o    (lat_double_o)
   );

endmodule

// File: rtl/rwds_lat_sampler_chk.sv
module rwds_lat_sampler_chk #(
   parameter int unsigned CNT_W = 3
) (
   input logic             clk_i,
   input logic             clk_phy_i,
   input logic             rst_ni,
   input logic             cs_n_i,
   input logic             no_lat_i,
   input logic             ck_en_o,
   input logic             lat_valid_o,
   input logic             lat_double_o,
   input logic             start_w,
   input logic             armed_w,
   input logic [CNT_W-1:0] cnt_w,
   input logic [CNT_W-1:0] hit_idx_w,
   input logic             sample_w
);

   AST_CNT_WITHIN_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_w |-> (cnt_w <= hit_idx_w)); // R1

   AST_ZERO_LAT_NO_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_w && no_lat_i) |=> !armed_w); // R5

   AST_CKEN_OFF_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cs_n_i |=> !ck_en_o); // R7

   AST_CKEN_OFF_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_w |=> !ck_en_o); // R7

   AST_VALID_SINGLE: assert property (@(posedge clk_phy_i) disable iff (!rst_ni)
      lat_valid_o |=> !lat_valid_o); // R4

   AST_FLAG_IS_SAMPLE: assert property (@(posedge clk_phy_i) disable iff (!rst_ni)
      lat_valid_o |-> (lat_double_o == sample_w)); // R3

endmodule

bind rwds_lat_sampler rwds_lat_sampler_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i        (clk_i),
   .clk_phy_i    (clk_phy_i),
   .rst_ni       (rst_ni),
   .cs_n_i       (cs_n_i),
   .no_lat_i     (no_lat_i),
   .ck_en_o      (ck_en_o),
   .lat_valid_o  (lat_valid_o),
   .lat_double_o (lat_double_o),
   .start_w      (start_w),
   .armed_w      (armed_w),
   .cnt_w        (cnt_w),
   .hit_idx_w    (hit_idx_w),
   .sample_w     (sample_w)
);

// File: tb/rwds_lat_sampler_tb_top.sv
module rwds_lat_sampler_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       rwds = 1'b0;
   logic       no_lat = 1'b0;
   logic [3:0] spt = 4'd1;
   logic [2:0] ckd = 3'd1;
   logic       ck_en;
   logic       lvalid;
   logic       ldouble;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   rwds_lat_sampler dut_i (
      .clk_i        (clk),
      .clk_phy_i    (clk),
      .rst_ni       (rst_n),
      .cs_n_i       (cs_n),
      .rwds_i       (rwds),
      .no_lat_i     (no_lat),
      .sample_pt_i  (spt),
      .ck_delay_i   (ckd),
      .ck_en_o      (ck_en),
      .lat_valid_o  (lvalid),
      .lat_double_o (ldouble)
   );

   // Vector: {target[20:17], level[16], win_lo[15:10], win_hi[9:4], zero_lat[3], ck_delay[2:0]}
   localparam int NV = 11;
   localparam logic [20:0] VEC [NV] = '{
      {4'd1,  1'b1, 6'd1,  6'd1,  1'b0, 3'd1},  // R1 first falling edge
      {4'd2,  1'b1, 6'd1,  6'd1,  1'b0, 3'd1},  // R1 one half-edge too late
      {4'd5,  1'b1, 6'd4,  6'd6,  1'b0, 3'd2},  // R3 high -> double
      {4'd5,  1'b0, 6'd4,  6'd6,  1'b0, 3'd3},  // R3 low -> single
      {4'd0,  1'b1, 6'd1,  6'd1,  1'b0, 3'd1},  // R2 zero acts as one
      {4'd15, 1'b1, 6'd15, 6'd15, 1'b0, 3'd4},  // R1 last odd setting
      {4'd14, 1'b1, 6'd15, 6'd15, 1'b0, 3'd1},  // R1 even setting before window
      {4'd6,  1'b1, 6'd5,  6'd7,  1'b0, 3'd0},  // R7 delay zero acts as one
      {4'd4,  1'b1, 6'd4,  6'd6,  1'b0, 3'd5},  // R7 long clock delay
      {4'd3,  1'b1, 6'd0,  6'd3,  1'b1, 3'd2},  // R5 / R8 zero-latency write
      {4'd6,  1'b0, 6'd2,  6'd9,  1'b0, 3'd7}   // R3 low across wide window
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_txn(input logic [20:0] v);
      int  tgt   = int'(v[20:17]);
      bit  lvl   = v[16];
      int  lo    = int'(v[15:10]);
      int  hi    = int'(v[9:4]);
      bit  zl    = v[3];
      int  dly   = int'(v[2:0]);
      int  teff  = (tgt == 0) ? 1 : tgt;
      int  d     = (dly == 0) ? 1 : dly;
      int  vk    = (teff - 1) / 2 + 3;
      bit  expf  = (teff >= lo && teff <= hi) ? lvl : ~lvl;
      int  nvalid = 0;
      int  vat   = -1;
      bit  fval  = 1'b0;
      bit  ck_ok = 1'b1;
      int  ck_bad = 0;
      @(negedge clk); #5;
      spt = v[20:17]; ckd = v[2:0]; no_lat = zl;
      cs_n = 1'b0;
      for (int e = 0; e < 40; e++) begin
         rwds = (e >= lo && e <= hi) ? lvl : ~lvl;
         if (e % 2 == 0) @(posedge clk); else @(negedge clk);
         #5;
         if (e == 0) begin   // R6: later config changes must be ignored
            spt = ~v[20:17]; ckd = ~v[2:0]; no_lat = ~zl;
         end
         if (e % 2 == 0) begin
            if (ck_en !== ((e / 2) >= d)) begin ck_ok = 1'b0; ck_bad = e / 2; end
            if (lvalid) begin nvalid++; vat = e / 2; fval = ldouble; end
         end
      end
      check(ck_ok, "R7 clock-start delay", ck_bad, d);
      if (zl) begin
         check(nvalid == 0, "R5 no valid on zero-latency", nvalid, 0);
         check(ldouble == 1'b0, "R8 stale flag cleared", int'(ldouble), 0);
      end else begin
         check(nvalid == 1, "R4 single valid pulse", nvalid, 1);
         check(vat == vk, "R4 valid cycle", vat, vk);
         check(fval == expf, "R1 R3 R6 sampled level", int'(fval), int'(expf));
      end
      cs_n = 1'b1; rwds = 1'b0;
      @(posedge clk); #5;
      check(ck_en == 1'b0, "R7 clock off after deselect", int'(ck_en), 0);
      repeat (3) @(posedge clk);
   endtask

   initial begin
      #1;
      check(ck_en == 0 && lvalid == 0 && ldouble == 0, "R9 reset state",
            int'({ck_en, lvalid, ldouble}), 0);
      repeat (3) @(posedge clk);
      #5 rst_n = 1'b1;
      repeat (2) @(posedge clk);
      for (int i = 0; i < NV; i++) run_txn(VEC[i]);

      // Directed: flag set, then a new fall clears it (R8) and reset mid-transaction (R9)
      run_txn({4'd2, 1'b1, 6'd0, 6'd20, 1'b0, 3'd1});
      check(ldouble == 1'b1, "R3 flag held after transaction", int'(ldouble), 1);
      @(negedge clk); #5;
      spt = 4'd9; ckd = 3'd1; no_lat = 1'b0; cs_n = 1'b0;
      @(posedge clk); #5;
      @(posedge clk); #5;
      check(ck_en == 1'b1, "R7 clock on before reset", int'(ck_en), 1);
      rst_n = 1'b0;
      #1;
      check(ck_en == 0 && lvalid == 0 && ldouble == 0, "R9 reset mid-transaction",
            int'({ck_en, lvalid, ldouble}), 0);
      cs_n = 1'b1;
      repeat (2) @(posedge clk);
      #5 rst_n = 1'b1;
      run_txn({4'd3, 1'b1, 6'd3, 6'd3, 1'b0, 3'd2});  // R1 recovery after reset
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule